// File: doc/BRIEF.md
# Timer-Paced Serial ADC Frame Master

This block is the master side of a three-wire serial link to a 12-bit converter that returns its sample inside a 16-bit word. It makes the serial clock from the system clock through a programmable divider and drives an active-low frame strobe. It shifts in the returned bits and presents the low 12 bits of each word as a result, with a one-cycle strobe. The 12 bits sit right-justified under four leading bits that the block discards.

Conversions are paced by an internal interval timer. Each timer expiry raises a start request. A request does not begin a frame at once: the block waits until it has seen the serial clock high, then low, and then rising again. Every frame therefore starts on a serial-clock rising edge. The spacing of frames is even only when the timer period is a whole number of serial-clock periods. When the timer period is a whole number plus a half, consecutive frame spacings alternate between one half period shorter and one half period longer than the timer period. A power-down setting, sampled when a frame starts, shortens that frame to an 8-clock burst that yields no result.

Top module: `sadc_frame_master`

## Requirements
- R1: After synchronous active-high reset, `fs_n_o` is 1, `sclk_o` is 1 and `result_valid_o` is 0, and the timer is cleared.
- R2: The serial clock has a period of 2*(div_cfg+1) system clocks, and `sclk_o` stays high whenever `fs_n_o` is high.
- R3: With `pd_mode` low at the start, a frame holds `fs_n_o` low for exactly 16 serial-clock periods and shows 16 falling edges of `sclk_o`. It ends in the cycle in which `sclk_o` rises.
- R4: `sdata_i` is sampled at each falling edge of `sclk_o` during a frame, most significant bit first. `result_o` equals bits [11:0] of the 16-bit word received, so bits [15:12] have no effect.
- R5: `result_valid_o` is a single-cycle pulse. It is raised in the cycle in which `fs_n_o` returns high after a full frame, once per such frame, with results in frame order.
- R6: When `pd_mode` is 1 at the frame start, the frame lasts 8 serial-clock periods with 8 falling edges, and no `result_valid_o` pulse follows it.
- R7: While `tmr_en` is high, the timer expires every period_cfg+1 system clocks. Each expiry produces exactly one frame. While `tmr_en` is low, no frame starts.
- R8: After a request, a frame begins only at a serial-clock rising edge that follows an observed high level and then a low level. `sclk_o` is high in the cycle in which `fs_n_o` falls.
- R9: When period_cfg+1 is a whole multiple of the serial-clock period, every interval between successive `fs_n_o` falling edges equals period_cfg+1.
- R10: When period_cfg+1 is a whole number of serial-clock periods plus one half, successive frame intervals alternate between period_cfg+1 minus and plus half a serial-clock period.
- R11: Requests that arrive while a frame is running or waiting are counted, up to 2^PEND_W-1. Each one is served later by its own frame, and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_cfg | input | DIV_W | Serial clock divider; period is 2*(div_cfg+1) system clocks |
| period_cfg | input | TMR_W | Timer interval minus one, in system clocks |
| tmr_en | input | 1 | Enables the pacing timer |
| pd_mode | input | 1 | 1 makes the next frame an 8-clock power-down burst |
| sdata_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock, idle high |
| fs_n_o | output | 1 | Active-low frame strobe |
| result_o | output | DATA_W | Right-justified conversion result |
| result_valid_o | output | 1 | One-cycle strobe for result_o |

## Verification
The hardest condition to reach from the ports is the alternating start delay. It appears only when the timer expiry moves by half a serial-clock period from one interval to the next, so that requests land on opposite clock levels in turn. The stimulus sets a divider of 1 and a timer interval of 402 system clocks, which is 100.5 serial-clock periods. It then runs several frames and checks that the start intervals take the values 400 and 404 in turn. A second hard case is a backlog of requests. To create one, the timer runs at 40-cycle intervals, shorter than one frame, for exactly five expiries and is then stopped. The bench then checks that five frames and five results still come out.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

   typedef enum logic [1:0] {
      GATE_IDLE,
      GATE_SEE_HI,
      GATE_SEE_LO,
      GATE_SEE_RISE
   } gate_st_t;

   typedef enum logic {
      ENG_IDLE,
      ENG_SHIFT
   } eng_st_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] div_cfg,
   output logic             sclk_q,
   output logic             rise_p,
   output logic             fall_p
);

   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   // >= keeps the divider from stalling when div_cfg is lowered mid-count
   assign wrap   = (cnt_q >= div_cfg);
   assign rise_p = wrap & ~sclk_q;
   assign fall_p = wrap &  sclk_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         sclk_q <= 1'b1;
      end else if (wrap) begin
         cnt_q  <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sadc_pace_timer.sv
module sadc_pace_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [TMR_W-1:0] period_cfg,
   output logic             tick
);

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (cnt_q >= period_cfg) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         tick  <= 1'b0;
      end
   end

endmodule

// File: rtl/sadc_start_gate.sv
module sadc_start_gate
   import sadc_pkg::*;
#(
   parameter int PEND_W = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic busy,
   input  logic sclk_q,
   input  logic rise_p,
   output logic start_p
);

   localparam logic [PEND_W-1:0] PEND_MAX = '1;

   gate_st_t          st_q;
   logic [PEND_W-1:0] pend_q;
   logic              take;

   assign take    = tick && (pend_q != PEND_MAX);
   assign start_p = (st_q == GATE_SEE_RISE) && rise_p;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= '0;
      end else begin
         case ({take, start_p})
            2'b10:   pend_q <= pend_q + 1'b1;
            2'b01:   pend_q <= pend_q - 1'b1;
            default: pend_q <= pend_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= GATE_IDLE;
      end else begin
         case (st_q)
            GATE_IDLE:     if (pend_q != '0 && !busy) st_q <= GATE_SEE_HI;
            GATE_SEE_HI:   if (sclk_q)                st_q <= GATE_SEE_LO;
            GATE_SEE_LO:   if (!sclk_q)               st_q <= GATE_SEE_RISE;
            GATE_SEE_RISE: if (rise_p)                st_q <= GATE_IDLE;
            default:                                  st_q <= GATE_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sadc_frame_engine.sv
module sadc_frame_engine
   import sadc_pkg::*;
#(
   parameter int FRAME_BITS = 16,
   parameter int PD_BITS    = 8,
   parameter int DATA_W     = 12,
   parameter bit PD_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_p,
   input  logic              rise_p,
   input  logic              fall_p,
   input  logic              pd_mode,
   input  logic              sdata,
   output logic              busy,
   output logic              fs_n,
   output logic [DATA_W-1:0] result,
   output logic              valid
);

   localparam int CW = cnt_width(FRAME_BITS);
   localparam logic [CW-1:0] FULL_LEN = CW'(FRAME_BITS);
   localparam logic [CW-1:0] BURST_LEN = CW'(PD_BITS);

   eng_st_t               st_q;
   logic [CW-1:0]         nbits_q;
   logic [CW-1:0]         target;
   logic                  pd_q;
   logic                  pd_take;
   logic [FRAME_BITS-1:0] sr_q;

   generate
      if (PD_EN) begin : g_pd
         assign pd_take = pd_mode;
      end else begin : g_no_pd
         assign pd_take = 1'b0;
      end
   endgenerate

   assign target = pd_q ? BURST_LEN : FULL_LEN;
   assign busy   = (st_q == ENG_SHIFT);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ENG_IDLE;
         fs_n    <= 1'b1;
         valid   <= 1'b0;
         result  <= '0;
         sr_q    <= '0;
         nbits_q <= '0;
         pd_q    <= 1'b0;
      end else begin
         valid <= 1'b0;
         case (st_q)
            ENG_IDLE: begin
               if (start_p) begin
                  st_q    <= ENG_SHIFT;
                  fs_n    <= 1'b0;
                  nbits_q <= '0;
                  pd_q    <= pd_take;
                  sr_q    <= '0;
               end
            end
            ENG_SHIFT: begin
               if (fall_p && nbits_q != target) begin
                  sr_q    <= {sr_q[FRAME_BITS-2:0], sdata};
                  nbits_q <= nbits_q + 1'b1;
               end else if (rise_p && nbits_q == target) begin
                  st_q <= ENG_IDLE;
                  fs_n <= 1'b1;
                  if (!pd_q) begin
                     valid  <= 1'b1;
                     result <= sr_q[DATA_W-1:0];
                  end
               end
            end
            default: st_q <= ENG_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sadc_frame_master.sv
module sadc_frame_master #(
   parameter int DIV_W      = 8,
   parameter int TMR_W      = 16,
   parameter int FRAME_BITS = 16,
   parameter int PD_BITS    = 8,
   parameter int DATA_W     = 12,
   parameter int PEND_W     = 3,
   parameter bit PD_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DIV_W-1:0]  div_cfg,
   input  logic [TMR_W-1:0]  period_cfg,
   input  logic              tmr_en,
   input  logic              pd_mode,
   input  logic              sdata_i,
   output logic              sclk_o,
   output logic              fs_n_o,
   output logic [DATA_W-1:0] result_o,
   output logic              result_valid_o
);

   generate
      if (DATA_W > FRAME_BITS || DATA_W < 1) begin : g_bad_data_w
         $error("sadc_frame_master: DATA_W must be 1..FRAME_BITS");
      end
      if (PD_BITS < 1 || PD_BITS >= FRAME_BITS) begin : g_bad_pd_bits
         $error("sadc_frame_master: PD_BITS must be 1..FRAME_BITS-1");
      end
      if (FRAME_BITS < 2) begin : g_bad_frame
         $error("sadc_frame_master: FRAME_BITS must be at least 2");
      end
      if (DIV_W < 1 || TMR_W < 1 || PEND_W < 1) begin : g_bad_widths
         $error("sadc_frame_master: widths must be positive");
      end
   endgenerate

   logic sclk_q;
   logic rise_p;
   logic fall_p;
   logic tick;
   logic start_p;
   logic busy;

   sadc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
      .clk     (clk),
      .rst     (rst),
      .div_cfg (div_cfg),
      .sclk_q  (sclk_q),
      .rise_p  (rise_p),
      .fall_p  (fall_p)
   );

   sadc_pace_timer #(.TMR_W(TMR_W)) u_timer (
      .clk        (clk),
      .rst        (rst),
      .en         (tmr_en),
      .period_cfg (period_cfg),
      .tick       (tick)
   );

   sadc_start_gate #(.PEND_W(PEND_W)) u_gate (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .busy    (busy),
      .sclk_q  (sclk_q),
      .rise_p  (rise_p),
      .start_p (start_p)
   );

   sadc_frame_engine #(
      .FRAME_BITS (FRAME_BITS),
      .PD_BITS    (PD_BITS),
      .DATA_W     (DATA_W),
      .PD_EN      (PD_EN)
   ) u_engine (
      .clk     (clk),
      .rst     (rst),
      .start_p (start_p),
      .rise_p  (rise_p),
      .fall_p  (fall_p),
      .pd_mode (pd_mode),
      .sdata   (sdata_i),
      .busy    (busy),
      .fs_n    (fs_n_o),
      .result  (result_o),
      .valid   (result_valid_o)
   );

   assign sclk_o = busy ? sclk_q : 1'b1;

endmodule

// File: rtl/sadc_chk.sv
module sadc_chk (
   input logic clk,
   input logic rst,
   input logic fs_n,
   input logic sclk,
   input logic valid
);

   // R1
   rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (fs_n && sclk && !valid));

   // R2
   idle_sclk_high_chk: assert property (@(posedge clk) disable iff (rst)
      fs_n |-> sclk);

   // R8
   start_on_high_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(fs_n) |-> sclk);

   // R3
   end_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(fs_n) |-> (sclk && !$past(sclk)));

   // R5
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      valid |=> !valid);

   // R5
   valid_at_end_chk: assert property (@(posedge clk) disable iff (rst)
      valid |-> $rose(fs_n));

endmodule

bind sadc_frame_master sadc_chk u_chk (
   .clk   (clk),
   .rst   (rst),
   .fs_n  (fs_n_o),
   .sclk  (sclk_o),
   .valid (result_valid_o)
);

// File: tb/sadc_frame_master_tb.sv
`timescale 1ns/1ps
module sadc_frame_master_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  div_cfg = 8'd1;
   logic [15:0] period_cfg = 16'd399;
   logic        tmr_en = 1'b0;
   logic        pd_mode = 1'b0;
   logic        sdata = 1'b0;
   logic        sclk_o, fs_n_o, result_valid_o;
   logic [11:0] result_o;

   always #2 clk = ~clk;

   sadc_frame_master u_dut (
      .clk(clk), .rst(rst), .div_cfg(div_cfg), .period_cfg(period_cfg),
      .tmr_en(tmr_en), .pd_mode(pd_mode), .sdata_i(sdata),
      .sclk_o(sclk_o), .fs_n_o(fs_n_o), .result_o(result_o),
      .result_valid_o(result_valid_o)
   );

   int n_chk = 0, n_bad = 0;
   int cyc = 0;
   bit done = 0;
   int starts[$];
   logic [11:0] exp_q[$];
   int frame_idx = 0, n_valid = 0;
   int exp_bits = 16, exp_T = 4;
   int fstart = 0, nfall = 0, last_fall = -1, bit_i = 0;
   logic [15:0] word = '0;
   logic prev_fs = 1'b1, prev_sclk = 1'b1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] mk_word(input int k);
      return 16'hB3C5 + 16'(k) * 16'h2A71;
   endfunction

   // driver side of the scoreboard: converter model pushes expected results
   always @(negedge clk) begin
      cyc++;
      if (!rst) begin
         if (prev_fs && !fs_n_o) begin
            word = mk_word(frame_idx);
            frame_idx++;
            if (!pd_mode) exp_q.push_back(word[11:0]);
            bit_i = 15;
            sdata = word[15];
            starts.push_back(cyc);
            fstart = cyc; nfall = 0; last_fall = -1;
            check(sclk_o == 1'b1, "R8", "sclk at frame start", int'(sclk_o), 1);
         end else if (!fs_n_o && prev_sclk && !sclk_o) begin
            nfall++;
            if (last_fall >= 0)
               check(cyc - last_fall == exp_T, "R2", "sclk period", cyc - last_fall, exp_T);
            last_fall = cyc;
            if (bit_i > 0) begin
               bit_i--;
               sdata = word[bit_i];
            end
         end
         if (!prev_fs && fs_n_o) begin
            check(nfall == exp_bits, pd_mode ? "R6" : "R3", "falling edges", nfall, exp_bits);
            check(cyc - fstart == exp_bits * exp_T, pd_mode ? "R6" : "R3",
                  "frame length", cyc - fstart, exp_bits * exp_T);
         end
         // monitor side: compare each result against the queue
         if (result_valid_o) begin
            n_valid++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R6", "unexpected result_valid", 1, 0);
            end else begin
               logic [11:0] e;
               e = exp_q.pop_front();
               check(result_o == e, "R4", "result word", int'(result_o), int'(e));
            end
         end
      end
      prev_fs = fs_n_o;
      prev_sclk = sclk_o;
   end

   task automatic run_phase(input int dv, input int per, input bit pd, input int n,
                            output int base);
      int guard;
      div_cfg = 8'(dv);
      period_cfg = 16'(per);
      pd_mode = pd;
      exp_bits = pd ? 8 : 16;
      exp_T = 2 * (dv + 1);
      base = starts.size();
      tmr_en = 1'b1;
      guard = 0;
      while (starts.size() < base + n && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      tmr_en = 1'b0;
      check(starts.size() >= base + n, "R7", "frames started", starts.size() - base, n);
      guard = 0;
      while (!fs_n_o && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      repeat (20) @(negedge clk);
   endtask

   initial begin
      int base, v0, prev_iv;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check(fs_n_o == 1'b1, "R1", "fs_n after reset", int'(fs_n_o), 1);
      check(sclk_o == 1'b1, "R1", "sclk after reset", int'(sclk_o), 1);
      check(result_valid_o == 1'b0, "R1", "valid after reset", int'(result_valid_o), 0);
      repeat (10) @(negedge clk);

      // R9: 400 = 100 serial periods of 4 cycles
      run_phase(1, 399, 1'b0, 4, base);
      for (int i = base + 1; i < base + 4; i++)
         check(starts[i] - starts[i-1] == 400, "R9", "interval", starts[i] - starts[i-1], 400);

      // R10: 402 = 100.5 serial periods
      run_phase(1, 401, 1'b0, 5, base);
      prev_iv = 0;
      for (int i = base + 1; i < base + 5; i++) begin
         int iv;
         iv = starts[i] - starts[i-1];
         check(iv == 400 || iv == 404, "R10", "interval value", iv, 402);
         if (prev_iv != 0)
            check(iv != prev_iv, "R10", "interval alternation", iv, 804 - prev_iv);
         prev_iv = iv;
      end

      // R6: power-down bursts, no result
      v0 = n_valid;
      run_phase(1, 399, 1'b1, 2, base);
      check(n_valid == v0, "R6", "valid count in power-down", n_valid - v0, 0);

      // R2 / R9 with divider 3: 8-cycle serial clock
      run_phase(3, 799, 1'b0, 2, base);
      check(starts[base+1] - starts[base] == 800, "R9", "interval div3",
            starts[base+1] - starts[base], 800);

      // R11: five requests at 40-cycle spacing, faster than frames run
      div_cfg = 8'd1; period_cfg = 16'd39; pd_mode = 1'b0;
      exp_bits = 16; exp_T = 4;
      repeat (20) @(negedge clk);
      base = starts.size();
      v0 = n_valid;
      tmr_en = 1'b1;
      repeat (220) @(negedge clk);
      tmr_en = 1'b0;
      repeat (2500) @(negedge clk);
      check(starts.size() - base == 5, "R11", "frames from backlog", starts.size() - base, 5);
      check(n_valid - v0 == 5, "R11", "results from backlog", n_valid - v0, 5);
      // R7: timer off, nothing more starts
      repeat (1000) @(negedge clk);
      check(starts.size() - base == 5, "R7", "frames with timer off", starts.size() - base, 5);
      check(exp_q.size() == 0, "R5", "results outstanding", exp_q.size(), 0);

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule